// File: doc/BRIEF.md
# Padded Control-Code Execution Pipeline

This block accepts one character from a host per character slot and moves it through a short chain of holding stages. A character is acted on only when it reaches the last stage, which is the execution stage. Text characters there are handed on as text once the block is idle. A recognised control code starts a display function. The block first waits for a cursor-found pulse from the refresh scan, then times the function, and ends it with a strobe that carries the code.

Control functions last longer than one slot, so the host follows each one with NULL characters. The block discards NULLs and unassigned low codes without acting on them. With the default timing, the text character after two NULLs of padding reaches the execution stage only after the function has finished. If a text or control character arrives at the execution stage early, the chain stalls on it and a sticky overrun flag is raised. If no cursor-found pulse arrives in time, the function is abandoned and a sticky timeout flag is raised.

The sequencer has three states. IDLE waits for work. SEARCH waits for the cursor. RUN times the function. IDLE goes to SEARCH when a fresh function code sits in the execution stage. SEARCH goes to RUN on cursor_found. SEARCH goes back to IDLE when the search window runs out. RUN goes to IDLE when the function time is up, and issues the strobe as it does so.

Top module: `pad_ctrl_pipe`

## Requirements
- R1: Synchronous active-high `rst` fills every stage with NULL (0x00). It clears `busy`, `overrun_err` and `search_timeout`. No text or function output follows from characters that were in the chain when reset was applied.
- R2: `take` pulses for one cycle once every SLOT_CYC cycles unless the chain is stalled, and the host character is captured on that edge. In an idle block, a text character (code 0x20 or above) produces a one-cycle `text_valid` with `text_char` equal to it exactly 2*SLOT_CYC+1 cycles after the edge that captured it. `text_valid` is never high while `busy` is high.
- R3: `wb_en` goes high together with `text_valid` while `xmit` is low, and stays low while `xmit` is high.
- R4: A function code (0x08, 0x11, 0x13 or 0x18) reaching the execution stage while idle raises `busy` one cycle later, and the block enters SEARCH.
- R5: A `cursor_found` pulse seen in SEARCH moves the block to RUN. `fn_strobe` then pulses with `fn_code` set to the code, in the cycle LONG_CYC+1 cycles after the pulse (STEP_CYC+1 for 0x13). `busy` is low in that same cycle. `fn_strobe` and `text_valid` are never high together.
- R6: NULL and the unassigned codes 0x01–0x1F other than the four function codes produce no busy, no text and no function. While the block is busy they pass through without raising `overrun_err`.
- R7: A text or function character that reaches the execution stage while `busy` is high sets the sticky `overrun_err` and stalls the chain. It is then handled normally, with its `text_valid` appearing exactly one cycle after `fn_strobe`.
- R8: If no `cursor_found` arrives within SEARCH_MAX cycles of entering SEARCH, `busy` drops and the sticky `search_timeout` rises in that same cycle, SEARCH_MAX cycles after `busy` first shows. No `fn_strobe` is issued.
- R9: A function code, two NULLs and then a text character give the text on `text_valid` after `fn_strobe`, with `overrun_err` still low, for any cursor delay within the search window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_char | input | 8 | Character offered by the host, captured when `take` is high |
| xmit | input | 1 | Transmit in progress; blocks write-back of text |
| cursor_found | input | 1 | Pulse from the scan logic: cursor position reached |
| take | output | 1 | Host character is captured at this edge |
| busy | output | 1 | A control function is in progress (SEARCH or RUN) |
| fn_strobe | output | 1 | One-cycle strobe: function finished |
| fn_code | output | 8 | Code of the finished function |
| text_valid | output | 1 | One-cycle strobe: text character from the execution stage |
| text_char | output | 8 | Text character |
| wb_en | output | 1 | Write text back to the recirculating store |
| overrun_err | output | 1 | Sticky: non-padding character arrived while busy |
| search_timeout | output | 1 | Sticky: cursor not found within the window |

## Verification
The hardest state to reach from the ports is an overrun. A real character has to be sitting in the execution stage while the function before it is still running, and the padding rule exists to prevent exactly that. The stimulus gets there by sending a backspace followed directly by a text character with no NULLs in between. It then holds back the cursor-found pulse until late in the search window, so the function is still in RUN when the text arrives one slot later. The bench then checks that the held character is released exactly one cycle after the strobe. The function timing checks drive cursor-found at several delays after `busy` appears, and measure the strobe position against the cycle of that pulse.

// File: rtl/pcp_pkg.sv
package pcp_pkg;

    typedef logic [7:0] chr_t;

    localparam chr_t C_NULL  = 8'h00;
    localparam chr_t C_BS    = 8'h08;
    localparam chr_t C_DC1   = 8'h11;
    localparam chr_t C_DC3   = 8'h13;
    localparam chr_t C_CAN   = 8'h18;
    localparam chr_t C_SPACE = 8'h20;

    typedef enum logic [1:0] {
        S_IDLE,
        S_SEARCH,
        S_RUN
    } seq_state_t;

    function automatic logic is_func(chr_t c);
        return (c == C_BS) || (c == C_DC1) || (c == C_DC3) || (c == C_CAN);
    endfunction

    function automatic logic is_text(chr_t c);
        return c >= C_SPACE;
    endfunction

    function automatic logic is_inert(chr_t c);
        return !is_func(c) && !is_text(c);
    endfunction

endpackage

// File: rtl/pcp_slot_timer.sv
module pcp_slot_timer #(
    parameter int SLOT_CYC = 80
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int W = $clog2(SLOT_CYC + 1);

    logic [W-1:0] cnt;

    assign tick = (cnt == W'(SLOT_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pcp_stage_chain.sv
module pcp_stage_chain
    import pcp_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic shift,
    input  chr_t din,
    input  logic consume,
    output chr_t head,
    output logic head_fresh
);
    chr_t stg  [DEPTH];
    chr_t feed [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_feed
        if (gi == 0) begin : g_in
            assign feed[gi] = din;
        end else begin : g_mid
            assign feed[gi] = stg[gi-1];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst) begin
                stg[i] <= C_NULL;
            end else if (shift) begin
                stg[i] <= feed[i];
            end
        end
    end

    // A character is fresh from the edge it enters the last stage until handled.
    always_ff @(posedge clk) begin
        if (rst) begin
            head_fresh <= 1'b0;
        end else if (shift) begin
            head_fresh <= 1'b1;
        end else if (consume) begin
            head_fresh <= 1'b0;
        end
    end

    assign head = stg[DEPTH-1];
endmodule

// File: rtl/pcp_func_seq.sv
module pcp_func_seq
    import pcp_pkg::*;
#(
    parameter int SEARCH_MAX = 76,
    parameter int LONG_CYC   = 76,
    parameter int STEP_CYC   = 72
) (
    input  logic clk,
    input  logic rst,
    input  chr_t head,
    input  logic head_fresh,
    input  logic cursor_found,
    output logic busy,
    output logic consume,
    output logic stall,
    output logic fn_strobe,
    output chr_t fn_code,
    output logic text_valid,
    output chr_t text_char,
    output logic overrun_err,
    output logic search_timeout
);
    localparam int M1   = (SEARCH_MAX > LONG_CYC) ? SEARCH_MAX : LONG_CYC;
    localparam int MAXD = (M1 > STEP_CYC) ? M1 : STEP_CYC;
    localparam int CW   = $clog2(MAXD + 1);

    seq_state_t    st, st_nx;
    logic [CW-1:0] cnt;
    logic [CW-1:0] run_last;
    chr_t          op;
    logic          start, expired, done;

    assign start    = head_fresh && is_func(head);
    assign expired  = (cnt == CW'(SEARCH_MAX - 1));
    assign run_last = (op == C_DC3) ? CW'(STEP_CYC - 1) : CW'(LONG_CYC - 1);
    assign done     = (cnt == run_last);

    assign busy    = (st != S_IDLE);
    assign consume = head_fresh && ((st == S_IDLE) || is_inert(head));
    assign stall   = head_fresh && busy && !is_inert(head);

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:   if (start) st_nx = S_SEARCH;
            S_SEARCH: begin
                if (cursor_found)  st_nx = S_RUN;
                else if (expired)  st_nx = S_IDLE;
            end
            S_RUN:    if (done) st_nx = S_IDLE;
            default:  st_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= S_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            op  <= C_NULL;
        end else begin
            cnt <= (st_nx != st) ? '0 : cnt + 1'b1;
            if (st == S_IDLE && start) begin
                op <= head;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fn_strobe      <= 1'b0;
            fn_code        <= C_NULL;
            text_valid     <= 1'b0;
            text_char      <= C_NULL;
            overrun_err    <= 1'b0;
            search_timeout <= 1'b0;
        end else begin
            fn_strobe  <= (st == S_RUN) && done;
            text_valid <= (st == S_IDLE) && head_fresh && is_text(head);
            if (st == S_RUN && done) begin
                fn_code <= op;
            end
            if (st == S_IDLE && head_fresh && is_text(head)) begin
                text_char <= head;
            end
            if (st == S_SEARCH && !cursor_found && expired) begin
                search_timeout <= 1'b1;
            end
            if (stall) begin
                overrun_err <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pad_ctrl_pipe.sv
module pad_ctrl_pipe
    import pcp_pkg::*;
#(
    parameter int SLOT_CYC   = 80,
    parameter int DEPTH      = 3,
    parameter int SEARCH_MAX = 76,
    parameter int LONG_CYC   = 76,
    parameter int STEP_CYC   = 72
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] host_char,
    input  logic       xmit,
    input  logic       cursor_found,
    output logic       take,
    output logic       busy,
    output logic       fn_strobe,
    output logic [7:0] fn_code,
    output logic       text_valid,
    output logic [7:0] text_char,
    output logic       wb_en,
    output logic       overrun_err,
    output logic       search_timeout
);
    logic tick, stall, consume, head_fresh;
    chr_t head;

    assign take  = tick && !stall;
    assign wb_en = text_valid && !xmit;

    pcp_slot_timer #(.SLOT_CYC(SLOT_CYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    pcp_stage_chain #(.DEPTH(DEPTH)) u_chain (
        .clk        (clk),
        .rst        (rst),
        .shift      (take),
        .din        (host_char),
        .consume    (consume),
        .head       (head),
        .head_fresh (head_fresh)
    );

    pcp_func_seq #(
        .SEARCH_MAX (SEARCH_MAX),
        .LONG_CYC   (LONG_CYC),
        .STEP_CYC   (STEP_CYC)
    ) u_seq (
        .clk            (clk),
        .rst            (rst),
        .head           (head),
        .head_fresh     (head_fresh),
        .cursor_found   (cursor_found),
        .busy           (busy),
        .consume        (consume),
        .stall          (stall),
        .fn_strobe      (fn_strobe),
        .fn_code        (fn_code),
        .text_valid     (text_valid),
        .text_char      (text_char),
        .overrun_err    (overrun_err),
        .search_timeout (search_timeout)
    );
endmodule

// File: rtl/pad_ctrl_pipe_chk.sv
module pad_ctrl_pipe_chk (
    input logic       clk,
    input logic       rst,
    input logic       take,
    input logic       busy,
    input logic       fn_strobe,
    input logic [7:0] fn_code,
    input logic       text_valid,
    input logic       overrun_err,
    input logic       search_timeout
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> !busy && !overrun_err && !search_timeout && !fn_strobe && !text_valid);

    a_r2_take_single: assert property (@(posedge clk) disable iff (rst)
        take |=> !take);

    a_r2_text_when_idle: assert property (@(posedge clk) disable iff (rst)
        text_valid |-> !busy);

    a_r5_code_legal: assert property (@(posedge clk) disable iff (rst)
        fn_strobe |-> (fn_code == 8'h08 || fn_code == 8'h11 || fn_code == 8'h13 || fn_code == 8'h18));

    a_r5_strobe_idle: assert property (@(posedge clk) disable iff (rst)
        fn_strobe |-> !busy);

    a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fn_strobe, text_valid}));

    a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        overrun_err |=> overrun_err);

    a_r8_timeout_sticky: assert property (@(posedge clk) disable iff (rst)
        search_timeout |=> search_timeout);

    a_r8_timeout_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(search_timeout) |-> !busy && !fn_strobe);
endmodule

bind pad_ctrl_pipe pad_ctrl_pipe_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .take           (take),
    .busy           (busy),
    .fn_strobe      (fn_strobe),
    .fn_code        (fn_code),
    .text_valid     (text_valid),
    .overrun_err    (overrun_err),
    .search_timeout (search_timeout)
);

// File: tb/pad_ctrl_pipe_bench.sv
`timescale 1ns/1ps
module pad_ctrl_pipe_bench;
    localparam int SLOT = 80;
    localparam int SMAX = 76;
    localparam int LONG = 76;
    localparam int STEP = 72;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] host_char = 8'h00;
    logic       xmit = 1'b0;
    logic       cursor_found = 1'b0;
    logic       take, busy, fn_strobe, text_valid, wb_en, overrun_err, search_timeout;
    logic [7:0] fn_code, text_char;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    int n_text, n_wb, n_fn, n_busy_rise;
    int last_text_cyc, last_fn_cyc, cur_cyc;
    logic [7:0] last_text, last_code;
    logic prev_busy = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pad_ctrl_pipe #(
        .SLOT_CYC(SLOT), .DEPTH(3), .SEARCH_MAX(SMAX), .LONG_CYC(LONG), .STEP_CYC(STEP)
    ) u_pad_ctrl_pipe (
        .clk(clk), .rst(rst), .host_char(host_char), .xmit(xmit),
        .cursor_found(cursor_found), .take(take), .busy(busy),
        .fn_strobe(fn_strobe), .fn_code(fn_code), .text_valid(text_valid),
        .text_char(text_char), .wb_en(wb_en), .overrun_err(overrun_err),
        .search_timeout(search_timeout)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (text_valid) begin
                n_text++; last_text = text_char; last_text_cyc = cyc;
                if (wb_en) n_wb++;
            end
            if (fn_strobe) begin
                n_fn++; last_code = fn_code; last_fn_cyc = cyc;
            end
            if (busy && !prev_busy) n_busy_rise++;
            prev_busy = busy;
        end else begin
            prev_busy = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        n_text = 0; n_wb = 0; n_fn = 0; n_busy_rise = 0;
        last_text_cyc = 0; last_fn_cyc = 0; cur_cyc = 0;
        last_text = 8'h00; last_code = 8'h00;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; host_char = 8'h00; cursor_found = 1'b0; xmit = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        clear_counts();
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Offer c and return just after the edge that captured it.
    task automatic push(input logic [7:0] c, output int edge_cyc);
        host_char = c;
        forever begin
            @(negedge clk);
            if (take) break;
        end
        @(posedge clk);
        #1;
        edge_cyc = cyc;
        host_char = 8'h00;
    endtask

    task automatic wait_busy(output int seen);
        seen = 0;
        for (int i = 0; i < 4 * SLOT; i++) begin
            @(negedge clk);
            if (busy) begin
                seen = cyc;
                return;
            end
        end
    endtask

    task automatic pulse_cursor(input int k);
        idle(k);
        cursor_found = 1'b1;
        cur_cyc = cyc;
        @(negedge clk);
        cursor_found = 1'b0;
    endtask

    task automatic t_reset();
        int e;
        do_reset();
        chk(!busy && !overrun_err && !search_timeout, "R1 flags after reset", {busy, overrun_err, search_timeout}, 0);
        chk(!text_valid && !fn_strobe, "R1 strobes after reset", {text_valid, fn_strobe}, 0);
        push("M", e);
        idle(SLOT);
        do_reset();
        idle(4 * SLOT);
        chk(n_text == 0 && n_fn == 0, "R1 chain flushed to NULL", n_text, 0);
    endtask

    task automatic t_text();
        int c0;
        do_reset();
        push("A", c0);
        idle(3 * SLOT);
        chk(n_text == 1 && last_text == "A", "R2 text delivered", last_text, "A");
        chk(last_text_cyc - c0 == 2 * SLOT + 1, "R2 text latency", last_text_cyc - c0, 2 * SLOT + 1);
        chk(n_wb == 1, "R3 write-back when receiving", n_wb, 1);
    endtask

    task automatic t_xmit();
        int c0;
        do_reset();
        xmit = 1'b1;
        push("X", c0);
        idle(3 * SLOT);
        chk(n_text == 1 && last_text == "X", "R3 text while transmitting", last_text, "X");
        chk(n_wb == 0, "R3 write-back blocked", n_wb, 0);
        xmit = 1'b0;
    endtask

    task automatic t_inert();
        int c0;
        do_reset();
        push(8'h01, c0);
        push(8'h1F, c0);
        idle(4 * SLOT);
        chk(n_busy_rise == 0 && n_text == 0 && n_fn == 0, "R6 inert codes ignored",
            n_busy_rise + n_text + n_fn, 0);
        chk(!overrun_err, "R6 no overrun from inert codes", overrun_err, 0);
    endtask

    task automatic t_func(input logic [7:0] code, input int dur, input int k);
        int c0, b, e;
        do_reset();
        push(code, c0);
        push(8'h00, e);
        push(8'h00, e);
        wait_busy(b);
        chk(b == c0 + 2 * SLOT + 1, "R4 busy after code reaches last stage", b - c0, 2 * SLOT + 1);
        fork
            pulse_cursor(k);
            push("Z", e);
        join
        idle(3 * SLOT);
        chk(n_fn == 1 && last_code == code, "R5 strobe carries code", last_code, code);
        chk(last_fn_cyc - cur_cyc == dur + 1, "R5 function duration", last_fn_cyc - cur_cyc, dur + 1);
        chk(n_text == 1 && last_text == "Z" && last_text_cyc > last_fn_cyc, "R9 padded text after function",
            last_text, "Z");
        chk(!overrun_err && !busy, "R9 no overrun with padding", {overrun_err, busy}, 0);
    endtask

    task automatic t_timeout();
        int c0, b;
        do_reset();
        push(8'h11, c0);
        wait_busy(b);
        idle(SMAX - 1);
        chk(busy && !search_timeout, "R8 still searching before window end", {busy, search_timeout}, 2);
        idle(1);
        chk(!busy && search_timeout, "R8 abort at window end", {busy, search_timeout}, 1);
        idle(2 * SLOT);
        chk(n_fn == 0 && search_timeout, "R8 no strobe, flag sticky", n_fn, 0);
    endtask

    task automatic t_overrun();
        int c0, b;
        do_reset();
        push(8'h08, c0);
        push("Q", c0);
        wait_busy(b);
        pulse_cursor(70);
        idle(30);
        chk(overrun_err == 1'b1 && busy, "R7 overrun raised", overrun_err, 1);
        idle(3 * SLOT);
        chk(n_fn == 1 && n_text == 1 && last_text == "Q", "R7 held char delivered", last_text, "Q");
        chk(last_text_cyc == last_fn_cyc + 1, "R7 release one cycle after strobe",
            last_text_cyc - last_fn_cyc, 1);
        chk(overrun_err == 1'b1, "R7 overrun sticky", overrun_err, 1);
    endtask

    initial begin
        t_reset();
        t_text();
        t_xmit();
        t_inert();
        t_func(8'h08, LONG, 0);
        t_func(8'h13, STEP, 5);
        t_func(8'h18, LONG, 40);
        t_func(8'h11, LONG, SMAX - 2);
        t_timeout();
        t_overrun();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1500000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule